// File: doc/BRIEF.md
# Configurable Peripheral Handshake Port Controller

This block is the control half of a bidirectional data port. A FIFO-side requester asks for one transfer at a time, either a write toward the external device or a read from it. The block then runs a request/acknowledge sequence on two pins and shapes the strobes that move the word. Timing and pin behaviour come from a 16-bit configuration word. That word picks the strobe style, the active level of each handshake pin, the request-to-acknowledge delay, the strobe length, an optional halving of the internal timebase and the direction of the port strobes.

In peripheral mode the block drives the two strobe pins and raises their output enable. In processor mode the strobe pins are inputs. The block synchronises them and reports each decoded read or write event as a one-cycle pulse. A configuration write that arrives during a transfer is parked. It is applied only once the sequencer is idle again, so a transfer always runs to its end with the settings it started with.

Top module: `hsk_port_ctrl`

## Requirements
- R1: Bit 0 selects strobe style. With 1, pin A is an active-low read strobe and pin B an active-low write strobe, and only the strobe for the transfer's direction goes low. With 0, pin A is an active-low data strobe and pin B is read/not-write (1 = read, 0 = write).
- R2: Bit 4 sets the request pin level: 0 makes it active high, 1 makes it active low.
- R3: Bit 5 sets the acknowledge pin level: 0 makes it active low, 1 makes it active high.
- R4: Bits 7:6 hold code c, and the request is active alone for 2+c internal ticks before the acknowledge asserts.
- R5: After one acknowledge tick, the strobe is active for 1 tick (bit 8 = 0) or 2 ticks (bit 8 = 1). One completion cycle follows with xfer_done high for exactly one cycle. Request and acknowledge then drop together, and the acknowledge is never active without the request.
- R6: Bit 9 = 1 makes the internal tick fire on every other clock, so each tick-counted interval lasts twice as many clocks.
- R7: Bit 10 = 1 (peripheral mode) drives the strobe pins with strb_oe high. With 0 (processor mode), strb_oe is low and both strobe outputs sit high.
- R8: In processor mode a falling edge on a strobe input, after a two-stage synchroniser, gives a one-cycle evt_rd or evt_wr pulse decoded per the bit 0 style. In peripheral mode the strobe inputs raise no event.
- R9: Bits 1 to 3 and 11 to 15 of the configuration are ignored on write and read back as zero.
- R10: A configuration write takes effect two clocks later when the sequencer is idle. During a transfer it is held until the sequencer returns to idle, and cfg_rdata stays unchanged while busy.
- R11: In data-strobe style, read/not-write equals the transfer direction and stays stable for the whole data-strobe pulse.
- R12: After reset the configuration is zero, the sequencer is idle, the request pin is low, the acknowledge pin is high and strb_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Active configuration, unused bits zero |
| xfer_req | input | 1 | Transfer request from the FIFO side, accepted when idle |
| xfer_wr | input | 1 | Transfer direction: 1 = write to device, 0 = read |
| xfer_busy | output | 1 | Sequencer not idle |
| xfer_done | output | 1 | One-cycle completion pulse |
| req_o | output | 1 | Handshake request pin |
| ack_o | output | 1 | Handshake acknowledge pin |
| strb_a_i | input | 1 | Strobe pin A as sampled in processor mode |
| strb_b_i | input | 1 | Strobe pin B as sampled in processor mode |
| strb_a_o | output | 1 | Strobe pin A drive |
| strb_b_o | output | 1 | Strobe pin B drive |
| strb_oe | output | 1 | Strobe pin output enable |
| evt_rd | output | 1 | Decoded read event in processor mode |
| evt_wr | output | 1 | Decoded write event in processor mode |

## Verification
The hardest case to reach from the ports is a configuration write that lands partway through a transfer running in halved-timebase mode. The new word must stay parked while the old strobe width and pin levels finish. The bench builds this by starting a long transfer (longest delay, wide strobe, divided tick) and issuing the write from inside its measurement loop a few cycles in. It then checks the strobe length, checks that the read-back word is unchanged while busy, and checks that the new word appears once idle. Halved-tick runs are also measured against a window, because the tick phase at acceptance is not controlled.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   localparam int BIT_STYLE   = 0;
   localparam int BIT_REQ_POL = 4;
   localparam int BIT_ACK_POL = 5;
   localparam int DLY_LO      = 6;
   localparam int DLY_W       = 2;
   localparam int BIT_WIDE    = 8;
   localparam int BIT_DIV2    = 9;
   localparam int BIT_MODE    = 10;
   localparam int CFG_MIN_W   = BIT_MODE + 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ACK,
      ST_STRB,
      ST_DONE
   } hsk_state_e;

   function automatic logic [31:0] cfg_mask32();
      logic [31:0] m;
      m = '0;
      m[BIT_STYLE]   = 1'b1;
      m[BIT_REQ_POL] = 1'b1;
      m[BIT_ACK_POL] = 1'b1;
      for (int i = 0; i < DLY_W; i++) m[DLY_LO + i] = 1'b1;
      m[BIT_WIDE]    = 1'b1;
      m[BIT_DIV2]    = 1'b1;
      m[BIT_MODE]    = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/hsk_tick_gen.sv
module hsk_tick_gen #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   output logic tick
);
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

   logic [PH_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (phase == PH_W'(DIV - 1))
         phase <= '0;
      else
         phase <= phase + 1'b1;
   end

   assign tick = slow ? (phase == PH_W'(DIV - 1)) : 1'b1;
endmodule

// File: rtl/hsk_cfg_reg.sv
module hsk_cfg_reg #(
   parameter int               CFG_W = 16,
   parameter logic [CFG_W-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             idle,
   output logic [CFG_W-1:0] active
);
   logic [CFG_W-1:0] shadow;
   logic             pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         pend   <= 1'b0;
         active <= '0;
      end else begin
         if (wr) begin
            shadow <= wdata & MASK;
            pend   <= 1'b1;
         end else if (pend && idle) begin
            pend   <= 1'b0;
         end
         if (pend && idle)
            active <= shadow;
      end
   end
endmodule

// File: rtl/hsk_seq.sv
module hsk_seq
   import hsk_pkg::*;
#(
   parameter int CNT_W    = 3,
   parameter int DLY_CW   = 2,
   parameter int DLY_BASE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              dir_wr,
   input  logic [DLY_CW-1:0] dly_code,
   input  logic              wide,
   output logic              busy,
   output logic              req_act,
   output logic              ack_act,
   output logic              strb_act,
   output logic              done,
   output logic              dir_q
);
   hsk_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dly_lim;
   logic [CNT_W-1:0] wid_lim;

   assign dly_lim = CNT_W'(DLY_BASE - 1) + CNT_W'(dly_code);
   assign wid_lim = CNT_W'(wide);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         dir_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st    <= ST_REQ;
               cnt   <= '0;
               dir_q <= dir_wr;
            end
            ST_REQ: if (tick) begin
               if (cnt == dly_lim) begin
                  st  <= ST_ACK;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ACK: if (tick) st <= ST_STRB;
            ST_STRB: if (tick) begin
               if (cnt == wid_lim) begin
                  st  <= ST_DONE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign req_act  = busy;
   assign ack_act  = (st == ST_ACK) || (st == ST_STRB) || (st == ST_DONE);
   assign strb_act = (st == ST_STRB);
   assign done     = (st == ST_DONE);
endmodule

// File: rtl/hsk_port_io.sv
module hsk_port_io #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic periph,
   input  logic sep_strobes,
   input  logic busy,
   input  logic strb_act,
   input  logic dir_wr,
   input  logic pin_a_i,
   input  logic pin_b_i,
   output logic pin_a_o,
   output logic pin_b_o,
   output logic oe,
   output logic evt_rd,
   output logic evt_wr
);
   logic [SYNC_STAGES-1:0] sa;
   logic [SYNC_STAGES-1:0] sb;
   logic                   pa, pb;
   logic                   a_s, b_s, fall_a, fall_b;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sa[gi] <= 1'b1;
                  sb[gi] <= 1'b1;
               end else begin
                  sa[gi] <= pin_a_i;
                  sb[gi] <= pin_b_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sa[gi] <= 1'b1;
                  sb[gi] <= 1'b1;
               end else begin
                  sa[gi] <= sa[gi-1];
                  sb[gi] <= sb[gi-1];
               end
            end
         end
      end
   endgenerate

   assign a_s = sa[SYNC_STAGES-1];
   assign b_s = sb[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa <= 1'b1;
         pb <= 1'b1;
      end else begin
         pa <= a_s;
         pb <= b_s;
      end
   end

   assign fall_a = pa & ~a_s;
   assign fall_b = pb & ~b_s;

   always_comb begin
      evt_rd = 1'b0;
      evt_wr = 1'b0;
      if (!periph) begin
         if (sep_strobes) begin
            evt_rd = fall_a;
            evt_wr = fall_b;
         end else begin
            evt_rd = fall_a & b_s;
            evt_wr = fall_a & ~b_s;
         end
      end
   end

   always_comb begin
      pin_a_o = 1'b1;
      pin_b_o = 1'b1;
      if (periph) begin
         if (sep_strobes) begin
            pin_a_o = ~(strb_act & ~dir_wr);
            pin_b_o = ~(strb_act & dir_wr);
         end else begin
            pin_a_o = ~strb_act;
            pin_b_o = busy ? ~dir_wr : 1'b1;
         end
      end
   end

   assign oe = periph;
endmodule

// File: rtl/hsk_port_ctrl.sv
module hsk_port_ctrl
   import hsk_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int DLY_BASE    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             xfer_req,
   input  logic             xfer_wr,
   output logic             xfer_busy,
   output logic             xfer_done,
   output logic             req_o,
   output logic             ack_o,
   input  logic             strb_a_i,
   input  logic             strb_b_i,
   output logic             strb_a_o,
   output logic             strb_b_o,
   output logic             strb_oe,
   output logic             evt_rd,
   output logic             evt_wr
);
   localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'(cfg_mask32());
   localparam int DLY_MAX = DLY_BASE + (1 << DLY_W) - 1;
   localparam int CNT_W   = $clog2(DLY_MAX + 1);

   generate
      if (CFG_W < CFG_MIN_W) begin : g_bad_cfg_w
         $error("CFG_W too small for configuration fields");
      end
      if (DLY_BASE < 1) begin : g_bad_base
         $error("DLY_BASE must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (TICK_DIV < 2) begin : g_bad_div
         $error("TICK_DIV must be at least 2");
      end
   endgenerate

   logic tick, busy, req_act, ack_act, strb_act, dir_q, start;

   hsk_cfg_reg #(.CFG_W(CFG_W), .MASK(CFG_MASK)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .idle(!busy), .active(cfg_rdata)
   );

   hsk_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .slow(cfg_rdata[BIT_DIV2]), .tick(tick)
   );

   assign start = xfer_req && !busy;

   hsk_seq #(.CNT_W(CNT_W), .DLY_CW(DLY_W), .DLY_BASE(DLY_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .dir_wr(xfer_wr),
      .dly_code(cfg_rdata[DLY_LO +: DLY_W]), .wide(cfg_rdata[BIT_WIDE]),
      .busy(busy), .req_act(req_act), .ack_act(ack_act), .strb_act(strb_act),
      .done(xfer_done), .dir_q(dir_q)
   );

   hsk_port_io #(.SYNC_STAGES(SYNC_STAGES)) u_io (
      .clk(clk), .rst_n(rst_n), .periph(cfg_rdata[BIT_MODE]),
      .sep_strobes(cfg_rdata[BIT_STYLE]), .busy(busy), .strb_act(strb_act),
      .dir_wr(dir_q), .pin_a_i(strb_a_i), .pin_b_i(strb_b_i),
      .pin_a_o(strb_a_o), .pin_b_o(strb_b_o), .oe(strb_oe),
      .evt_rd(evt_rd), .evt_wr(evt_wr)
   );

   assign req_o     = req_act ^ cfg_rdata[BIT_REQ_POL];
   assign ack_o     = ack_act ~^ cfg_rdata[BIT_ACK_POL];
   assign xfer_busy = busy;
endmodule

// File: rtl/hsk_port_ctrl_chk.sv
module hsk_port_ctrl_chk
   import hsk_pkg::*;
#(
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             xfer_busy,
   input logic             xfer_done,
   input logic             req_o,
   input logic             ack_o,
   input logic             strb_a_o,
   input logic             strb_b_o,
   input logic             strb_oe,
   input logic             evt_rd,
   input logic             evt_wr
);
   localparam logic [CFG_W-1:0] MASK = CFG_W'(cfg_mask32());

   logic req_on, ack_on;
   assign req_on = req_o != cfg_rdata[BIT_REQ_POL];
   assign ack_on = ack_o == cfg_rdata[BIT_ACK_POL];

   assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[BIT_MODE] && cfg_rdata[BIT_STYLE]) |-> (strb_a_o || strb_b_o));

   assert_ack_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_on |-> req_on);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   assert_proc_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[BIT_MODE] |-> (!strb_oe && strb_a_o && strb_b_o));

   assert_evt_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rd || evt_wr) |=> !(evt_rd || evt_wr));

   assert_no_evt_periph_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[BIT_MODE] |-> !(evt_rd || evt_wr));

   assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~MASK) == '0);

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy && $past(xfer_busy)) |-> $stable(cfg_rdata));

   assert_rnw_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[BIT_MODE] && !cfg_rdata[BIT_STYLE] && !strb_a_o && $past(!strb_a_o))
      |-> $stable(strb_b_o));
endmodule

bind hsk_port_ctrl hsk_port_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .xfer_busy(xfer_busy),
   .xfer_done(xfer_done), .req_o(req_o), .ack_o(ack_o), .strb_a_o(strb_a_o),
   .strb_b_o(strb_b_o), .strb_oe(strb_oe), .evt_rd(evt_rd), .evt_wr(evt_wr)
);

// File: tb/sim_hsk_port_ctrl.sv
`timescale 1ns/1ps
module sim_hsk_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        xfer_req = 1'b0, xfer_wr = 1'b0;
   logic        xfer_busy, xfer_done, req_o, ack_o;
   logic        strb_a_i = 1'b1, strb_b_i = 1'b1;
   logic        strb_a_o, strb_b_o, strb_oe, evt_rd, evt_wr;

   always #2 clk = ~clk;

   hsk_port_ctrl u0 (.*);

   int n_run = 0, n_fail = 0, cyc = 0;
   bit finished = 0;
   logic [15:0] cur_cfg = '0;

   localparam int NV = 6;
   localparam logic [15:0] V_CFG [NV] = '{16'h0421, 16'h05C1, 16'h0450, 16'h05A0, 16'h0621, 16'h0740};
   localparam bit          V_WR  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam int          V_RMN [NV] = '{2, 5, 3, 4, 3, 5};
   localparam int          V_RMX [NV] = '{2, 5, 3, 4, 4, 6};
   localparam int          V_STR [NV] = '{1, 2, 1, 2, 2, 4};
   localparam int          V_ACK [NV] = '{3, 4, 3, 4, 5, 7};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         chk(1'b0, "watchdog", cyc, 150000);
         summary();
      end
   end

   task automatic write_cfg(input logic [15:0] w);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_wr = 1'b0;
      @(negedge clk); @(negedge clk);
      cur_cfg = w & 16'h07F1;
   endtask

   int m_rta, m_ack, m_str, m_viol;
   bit m_done;

   task automatic run_xfer(input bit wr, input bit do_mid, input logic [15:0] mid_cfg);
      bit seen_ack, reqa, acka, stra, prev_ds;
      logic prev_b;
      m_rta = 0; m_ack = 0; m_str = 0; m_viol = 0; m_done = 0;
      seen_ack = 0; prev_ds = 0; prev_b = 1'b1;
      @(negedge clk); xfer_req = 1'b1; xfer_wr = wr;
      @(negedge clk); xfer_req = 1'b0;
      for (int n = 0; n < 200; n++) begin
         reqa = (req_o != cur_cfg[4]);
         acka = (ack_o == cur_cfg[5]);
         if (cur_cfg[0]) begin
            stra = !strb_a_o || !strb_b_o;
            if (!strb_a_o && !strb_b_o) m_viol++;
            if (stra && (wr ? !strb_a_o : !strb_b_o)) m_viol++;
         end else begin
            stra = !strb_a_o;
            if (stra && strb_b_o != !wr) m_viol++;
            if (stra && prev_ds && strb_b_o != prev_b) m_viol++;
         end
         prev_ds = !strb_a_o; prev_b = strb_b_o;
         if (acka) seen_ack = 1;
         if (reqa && !seen_ack) m_rta++;
         if (acka) m_ack++;
         if (stra) m_str++;
         if (do_mid && n == 2) begin cfg_wr = 1'b1; cfg_wdata = mid_cfg; end
         if (do_mid && n == 3) cfg_wr = 1'b0;
         if (do_mid && n == 6)
            chk(cfg_rdata == 16'h07C1 && xfer_busy, "R10 cfg held while busy", cfg_rdata, 16'h07C1);
         if (xfer_done) begin m_done = 1; break; end
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic count_evt(output int nr, output int nw);
      nr = 0; nw = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (evt_rd) nr++;
         if (evt_wr) nw++;
      end
   endtask

   int nr, nw;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(cfg_rdata == 16'h0000, "R12 cfg after reset", cfg_rdata, 0);
      chk(req_o == 1'b0 && ack_o == 1'b1, "R12 pins after reset", {req_o, ack_o}, 1);
      chk(!xfer_busy && !strb_oe, "R12 idle and undriven", {xfer_busy, strb_oe}, 0);

      // R9 unused bits read as zero
      write_cfg(16'hFFFF);
      chk(cfg_rdata == 16'h07F1, "R9 unused bits zero", cfg_rdata, 16'h07F1);

      // vector table: R1 R2 R3 R4 R5 R6 R11
      for (int v = 0; v < NV; v++) begin
         write_cfg(V_CFG[v]);
         chk(cfg_rdata == V_CFG[v], "R10 idle cfg applied", cfg_rdata, V_CFG[v]);
         chk(req_o == V_CFG[v][4], "R2 req idle level", req_o, V_CFG[v][4]);
         chk(ack_o == !V_CFG[v][5], "R3 ack idle level", ack_o, !V_CFG[v][5]);
         chk(strb_oe == 1'b1, "R7 periph drives", strb_oe, 1);
         run_xfer(V_WR[v], 1'b0, 16'h0);
         chk(m_done, "R5 done pulse", m_done, 1);
         chk(m_rta >= V_RMN[v] && m_rta <= V_RMX[v], "R4/R6 req to ack", m_rta, V_RMN[v]);
         chk(m_str == V_STR[v], "R5/R6 strobe length", m_str, V_STR[v]);
         chk(m_ack == V_ACK[v], "R5 ack length", m_ack, V_ACK[v]);
         chk(m_viol == 0, V_CFG[v][0] ? "R1 strobe select" : "R11 rnw stable", m_viol, 0);
         chk(req_o == V_CFG[v][4] && ack_o == !V_CFG[v][5], "R5 req ack drop",
             {req_o, ack_o}, {V_CFG[v][4], !V_CFG[v][5]});
      end

      // R10 configuration write during a transfer
      write_cfg(16'h07C1);
      run_xfer(1'b0, 1'b1, 16'h0421);
      chk(m_str == 4, "R10 old width kept", m_str, 4);
      @(negedge clk); @(negedge clk);
      cur_cfg = 16'h0421;
      chk(cfg_rdata == 16'h0421, "R10 new cfg after idle", cfg_rdata, 16'h0421);

      // R8 peripheral mode ignores inputs
      strb_a_i = 1'b0;
      count_evt(nr, nw);
      chk(nr == 0 && nw == 0, "R8 no event in periph", nr + nw, 0);
      strb_a_i = 1'b1;
      repeat (4) @(negedge clk);

      // R7 R8 processor mode, separate strobes
      write_cfg(16'h0001);
      chk(!strb_oe && strb_a_o && strb_b_o, "R7 proc undriven", {strb_oe, strb_a_o, strb_b_o}, 3);
      strb_a_i = 1'b0;
      count_evt(nr, nw);
      chk(nr == 1 && nw == 0, "R8 sep read event", nr * 10 + nw, 10);
      strb_a_i = 1'b1;
      repeat (4) @(negedge clk);
      strb_b_i = 1'b0;
      count_evt(nr, nw);
      chk(nr == 0 && nw == 1, "R8 sep write event", nr * 10 + nw, 1);
      strb_b_i = 1'b1;
      repeat (4) @(negedge clk);

      // R8 processor mode, data strobe style
      write_cfg(16'h0000);
      strb_b_i = 1'b0;
      repeat (4) @(negedge clk);
      strb_a_i = 1'b0;
      count_evt(nr, nw);
      chk(nr == 0 && nw == 1, "R8 ds write event", nr * 10 + nw, 1);
      strb_a_i = 1'b1; strb_b_i = 1'b1;
      repeat (4) @(negedge clk);
      strb_a_i = 1'b0;
      count_evt(nr, nw);
      chk(nr == 1 && nw == 0, "R8 ds read event", nr * 10 + nw, 10);
      strb_a_i = 1'b1;
      repeat (2) @(negedge clk);

      finished = 1;
      summary();
   end
endmodule